// File: doc/BRIEF.md
# Transmit Queue Service Request Generator

This block holds a small queue of bytes waiting to be serialised and decides when the processor or a DMA engine should be asked for more. The processor (or DMA) pushes bytes with a write strobe. The serializer takes the oldest byte through a pop strobe. From the queue occupancy the block derives a service condition. A configuration bit selects which condition is used: either at least one free slot exists, or the queue is completely drained.

The condition drives two things. The first is a sticky interrupt-pending flag. The second is a DMA request that appears on one of two active-low request pins. The primary pin is released in the same clock edge in which the write that satisfies the request is accepted. The alternate pin can be released in the same way, or a fixed number of clock periods later, as a second configuration bit selects. A hardware reset or a channel reset empties the queue and clears the configuration.

Top module: `txq_req_level`

## Requirements
- R1: The queue holds up to DEPTH (default 4) bytes in arrival order; `rd_valid` is 1 while it holds at least one byte and `rd_data` then shows the oldest one; a `pop` removes it, and both outputs reflect each accepted write or pop at the clock edge that accepts it.
- R2: A write while DEPTH bytes are held is dropped and `ovf` is 1 for exactly the one cycle after that edge.
- R3: With drain-level bit 0 the service condition is true whenever fewer than DEPTH bytes are held.
- R4: With drain-level bit 1 the service condition is true only when no byte is held.
- R5: `irq_pend` becomes 1 at the edge where the service condition changes from false to true, including a change caused by a configuration write. Otherwise it is cleared by an accepted write or by `pend_clr`, and setting wins over clearing.
- R6: `req_pri_n` is 0 exactly when `req_mode_en`=1, `alt_sel`=0 and the service condition holds, all evaluated on the state after the edge.
- R7: `req_alt_n` is 0 whenever `req_mode_en`=1, `alt_sel`=1 and the service condition holds.
- R8: With alt-fast bit 1, `req_alt_n` returns to 1 at the same edge at which its assert cause disappears.
- R9: With alt-fast bit 0, `req_alt_n` returns to 1 SLOW_CYC (default 4) edges after the edge at which its cause disappears; if the cause comes back during that wait, the pin stays 0.
- R10: `rst` or `chan_rst` (both synchronous, active-high) empty the queue, clear both configuration bits to 0 and `irq_pend` to 0, and drive both request pins to 1.
- R11: A `pop` while the queue is empty is ignored, and a write in the same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| chan_rst | input | 1 | Synchronous channel reset, active high |
| cfg_we | input | 1 | Loads both configuration bits |
| cfg_drain_lvl | input | 1 | 1: service when drained, 0: service when a slot is free |
| cfg_alt_fast | input | 1 | 1: alternate pin releases immediately, 0: after SLOW_CYC clocks |
| req_mode_en | input | 1 | Enables DMA request on transmit |
| alt_sel | input | 1 | Routes the request to the alternate pin |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | DATA_W | Byte to queue |
| pop | input | 1 | Serializer takes the oldest byte |
| pend_clr | input | 1 | Clears the interrupt-pending flag |
| rd_data | output | DATA_W | Oldest queued byte |
| rd_valid | output | 1 | Queue is not empty |
| ovf | output | 1 | One-cycle pulse for a dropped write |
| irq_pend | output | 1 | Transmit service interrupt pending |
| req_pri_n | output | 1 | Primary request pin, active low |
| req_alt_n | output | 1 | Alternate request pin, active low |

## Verification
The bench builds the block with its defaults: DATA_W 8, DEPTH 4 and SLOW_CYC 4. With only four slots, random write and pop rates regularly fill the queue, which produces overflow drops and full-to-free transitions. Both level selections are also exercised within a few cycles. A four-clock release delay is short enough that random toggling of the request enable, the pin select and the configuration often brings the cause back mid-wait, which exercises the cancellation path.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // Configuration held by the block; both bits clear on any reset.
  typedef struct packed {
    logic drain_lvl;  // 1: service only when queue is drained
    logic alt_fast;   // 1: alternate pin releases without delay
  } txq_cfg_t;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic              wr_acc,
  output logic [CW-1:0]     count_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              ovf
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count_q;
  logic              full, pop_ok;

  assign full   = (count_q == CW'(DEPTH));
  assign wr_acc = wr_en && !full;
  assign pop_ok = pop && (count_q != '0);

  always_comb begin
    count_n = count_q;
    if (wr_acc && !pop_ok)      count_n = count_q + CW'(1);
    else if (!wr_acc && pop_ok) count_n = count_q - CW'(1);
  end

  // Storage without reset so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count_q  <= '0;
      rd_valid <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      if (wr_acc) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (pop_ok) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      count_q  <= count_n;
      rd_valid <= (count_n != '0);
      ovf      <= wr_en && full;
    end
  end
endmodule

// File: rtl/txq_trig.sv
module txq_trig #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic [CW-1:0] count_n,
  input  logic          drain_lvl,
  input  logic          wr_acc,
  input  logic          pend_clr,
  output logic          cond_n,
  output logic          irq_pend
);
  logic cond_q;

  // Service condition on the state that follows this edge.
  assign cond_n = drain_lvl ? (count_n == '0) : (count_n < CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (clr) begin
      cond_q   <= 1'b1;   // an empty queue satisfies both selections
      irq_pend <= 1'b0;
    end else begin
      cond_q <= cond_n;
      if (cond_n && !cond_q)        irq_pend <= 1'b1;
      else if (wr_acc || pend_clr)  irq_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/txq_req_pins.sv
module txq_req_pins #(
  parameter int SLOW_CYC = 4,
  localparam int KW      = $clog2(SLOW_CYC + 1)
) (
  input  logic clk,
  input  logic clr,
  input  logic cond_n,
  input  logic mode_en,
  input  logic alt_sel,
  input  logic alt_fast,
  output logic req_pri_n,
  output logic req_alt_n
);
  logic          want_pri, want_alt;
  logic [KW-1:0] hold_cnt;

  assign want_pri = mode_en && !alt_sel && cond_n;
  assign want_alt = mode_en &&  alt_sel && cond_n;

  always_ff @(posedge clk) begin
    if (clr) req_pri_n <= 1'b1;
    else     req_pri_n <= !want_pri;
  end

  // Alternate pin: held low for SLOW_CYC edges after its cause ends,
  // unless the fast release is selected.
  always_ff @(posedge clk) begin
    if (clr) begin
      req_alt_n <= 1'b1;
      hold_cnt  <= '0;
    end else if (want_alt) begin
      req_alt_n <= 1'b0;
      hold_cnt  <= '0;
    end else if (!req_alt_n) begin
      if (hold_cnt != '0) begin
        if (hold_cnt == KW'(1)) begin
          req_alt_n <= 1'b1;
          hold_cnt  <= '0;
        end else begin
          hold_cnt <= hold_cnt - KW'(1);
        end
      end else if (alt_fast) begin
        req_alt_n <= 1'b1;
      end else begin
        hold_cnt <= KW'(SLOW_CYC);
      end
    end
  end
endmodule

// File: rtl/txq_req_level.sv
module txq_req_level #(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 4,
  parameter int SLOW_CYC = 4,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_rst,
  input  logic              cfg_we,
  input  logic              cfg_drain_lvl,
  input  logic              cfg_alt_fast,
  input  logic              req_mode_en,
  input  logic              alt_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  input  logic              pend_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              ovf,
  output logic              irq_pend,
  output logic              req_pri_n,
  output logic              req_alt_n
);
  import txq_pkg::*;

  logic          clr, wr_acc, cond_n;
  logic [CW-1:0] count_n;
  txq_cfg_t      cfg_q, cfg_n;

  assign clr = rst || chan_rst;

  always_comb begin
    cfg_n = cfg_q;
    if (cfg_we) cfg_n = '{drain_lvl: cfg_drain_lvl, alt_fast: cfg_alt_fast};
  end

  always_ff @(posedge clk) begin
    if (clr) cfg_q <= '0;
    else     cfg_q <= cfg_n;
  end

  txq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .clr(clr), .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
    .wr_acc(wr_acc), .count_n(count_n), .rd_data(rd_data),
    .rd_valid(rd_valid), .ovf(ovf)
  );

  txq_trig #(.DEPTH(DEPTH)) u_trig (
    .clk(clk), .clr(clr), .count_n(count_n), .drain_lvl(cfg_n.drain_lvl),
    .wr_acc(wr_acc), .pend_clr(pend_clr), .cond_n(cond_n), .irq_pend(irq_pend)
  );

  txq_req_pins #(.SLOW_CYC(SLOW_CYC)) u_pins (
    .clk(clk), .clr(clr), .cond_n(cond_n), .mode_en(req_mode_en),
    .alt_sel(alt_sel), .alt_fast(cfg_n.alt_fast),
    .req_pri_n(req_pri_n), .req_alt_n(req_alt_n)
  );
endmodule

// File: rtl/txq_req_level_chk.sv
module txq_req_level_chk (
  input logic clk,
  input logic rst,
  input logic chan_rst,
  input logic cfg_we,
  input logic req_mode_en,
  input logic alt_sel,
  input logic wr_en,
  input logic pop,
  input logic pend_clr,
  input logic rd_valid,
  input logic ovf,
  input logic irq_pend,
  input logic req_pri_n,
  input logic req_alt_n
);
  // R2: a dropped write needs a full queue and a write strobe
  a_r2_ovf_nonempty: assert property (@(posedge clk) disable iff (rst || chan_rst)
    ovf |-> rd_valid);
  a_r2_ovf_from_write: assert property (@(posedge clk) disable iff (rst || chan_rst)
    ovf |-> $past(wr_en));
  // R5: an explicit clear with no possible new cause leaves nothing pending
  a_r5_clear_pending: assert property (@(posedge clk) disable iff (rst || chan_rst)
    (pend_clr && !pop && !cfg_we) |=> !irq_pend);
  // R6: primary pin idle when request mode is off or the alternate pin is chosen
  a_r6_pri_mode_off: assert property (@(posedge clk) disable iff (rst || chan_rst)
    !req_mode_en |=> req_pri_n);
  a_r6_pri_alt_chosen: assert property (@(posedge clk) disable iff (rst || chan_rst)
    alt_sel |=> req_pri_n);
  // R7: alternate pin only starts a request when it is selected
  a_r7_alt_needs_sel: assert property (@(posedge clk) disable iff (rst || chan_rst)
    $fell(req_alt_n) |-> $past(alt_sel));
  // R11: popping an empty queue keeps it empty
  a_r11_empty_pop: assert property (@(posedge clk) disable iff (rst || chan_rst)
    (!rd_valid && !wr_en) |=> !rd_valid);
  // R10: either reset returns the outputs to idle
  a_r10_reset_idle: assert property (@(posedge clk)
    (rst || chan_rst) |=> (req_pri_n && req_alt_n && !irq_pend && !rd_valid));
endmodule

bind txq_req_level txq_req_level_chk u_chk (
  .clk(clk), .rst(rst), .chan_rst(chan_rst), .cfg_we(cfg_we),
  .req_mode_en(req_mode_en), .alt_sel(alt_sel), .wr_en(wr_en), .pop(pop),
  .pend_clr(pend_clr), .rd_valid(rd_valid), .ovf(ovf), .irq_pend(irq_pend),
  .req_pri_n(req_pri_n), .req_alt_n(req_alt_n)
);

// File: tb/test_txq_req_level.sv
module test_txq_req_level;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int SLOW   = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rst = 1'b1, chan_rst = 1'b0, cfg_we = 1'b0;
  logic cfg_drain_lvl = 1'b0, cfg_alt_fast = 1'b0;
  logic req_mode_en = 1'b0, alt_sel = 1'b0;
  logic wr_en = 1'b0, pop = 1'b0, pend_clr = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic rd_valid, ovf, irq_pend, req_pri_n, req_alt_n;

  txq_req_level #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SLOW_CYC(SLOW)) i_txq_req_level (
    .clk(clk), .rst(rst), .chan_rst(chan_rst), .cfg_we(cfg_we),
    .cfg_drain_lvl(cfg_drain_lvl), .cfg_alt_fast(cfg_alt_fast),
    .req_mode_en(req_mode_en), .alt_sel(alt_sel), .wr_en(wr_en),
    .wr_data(wr_data), .pop(pop), .pend_clr(pend_clr), .rd_data(rd_data),
    .rd_valid(rd_valid), .ovf(ovf), .irq_pend(irq_pend),
    .req_pri_n(req_pri_n), .req_alt_n(req_alt_n)
  );

  int checks = 0, errors = 0;

  // Reference state built from the requirements
  int mcnt = 0, hold = 0;
  logic [DATA_W-1:0] mq [DEPTH];
  bit mlvl, mfast, mirq, mprev = 1'b1, mpri = 1'b1, malt = 1'b1, movf;
  string alt_tag = "R7";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit svc_cond(int cnt, bit lvl);
    return lvl ? (cnt == 0) : (cnt < DEPTH);  // R3 / R4
  endfunction

  task automatic model_step();
    bit acc, dp, cond, want;
    if (rst || chan_rst) begin
      mcnt = 0; mlvl = 0; mfast = 0; mirq = 0; mprev = 1; mpri = 1;
      malt = 1; hold = 0; movf = 0;
      return;
    end
    acc  = wr_en && (mcnt < DEPTH);
    dp   = pop && (mcnt > 0);
    movf = wr_en && (mcnt == DEPTH);
    if (dp) begin
      for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i+1];
      mcnt--;
    end
    if (acc) begin mq[mcnt] = wr_data; mcnt++; end
    if (cfg_we) begin mlvl = cfg_drain_lvl; mfast = cfg_alt_fast; end
    cond = svc_cond(mcnt, mlvl);
    if (cond && !mprev) mirq = 1;
    else if (acc || pend_clr) mirq = 0;
    mprev = cond;
    mpri = !(req_mode_en && !alt_sel && cond);
    want = req_mode_en && alt_sel && cond;
    if (want) begin
      malt = 0; hold = 0; alt_tag = "R7";
    end else if (!malt) begin
      if (hold != 0) begin
        alt_tag = "R9";
        if (hold == 1) begin malt = 1; hold = 0; end
        else hold--;
      end else if (mfast) begin
        malt = 1; alt_tag = "R8";
      end else begin
        hold = SLOW; alt_tag = "R9";
      end
    end
  endtask

  task automatic check_all();
    chk("R1", rd_valid, mcnt != 0, "rd_valid");
    if (mcnt != 0) chk("R1", rd_data, mq[0], "rd_data");
    chk("R2", ovf, movf, "ovf");
    chk("R5", irq_pend, mirq, "irq_pend");
    chk("R6", req_pri_n, mpri, "req_pri_n");
    chk(alt_tag, req_alt_n, malt, "req_alt_n");
  endtask

  // One clock: inputs applied at the falling edge, outputs checked at the next one
  task automatic cyc(bit w, logic [DATA_W-1:0] d, bit p, bit c);
    wr_en = w; wr_data = d; pop = p; pend_clr = c;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
    wr_en = 0; pop = 0; pend_clr = 0;
  endtask

  task automatic set_cfg(bit lvl, bit fast);
    cfg_we = 1; cfg_drain_lvl = lvl; cfg_alt_fast = fast;
    cyc(0, '0, 0, 0);
    cfg_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    cyc(0, '0, 0, 0);
    cyc(0, '0, 0, 0);
    rst = 0;
    chk("R10", req_pri_n, 1, "pri after reset");
    chk("R10", req_alt_n, 1, "alt after reset");
    chk("R10", irq_pend, 0, "irq after reset");
    chk("R10", rd_valid, 0, "valid after reset");

    // Slot-free level
    req_mode_en = 1;
    cyc(0, '0, 0, 0);
    chk("R6", req_pri_n, 0, "pri with free slot");
    for (int i = 0; i < DEPTH; i++) cyc(1, DATA_W'(8'h10 + i), 0, 0);
    chk("R3", req_pri_n, 1, "pri when full");
    cyc(1, 8'hEE, 0, 0);
    chk("R2", ovf, 1, "ovf on full write");
    cyc(0, '0, 1, 0);
    chk("R3", req_pri_n, 0, "pri after one pop");
    chk("R5", irq_pend, 1, "irq on slot freed");
    cyc(0, '0, 0, 1);
    chk("R5", irq_pend, 0, "irq cleared");
    cyc(1, 8'h20, 0, 0);

    // Drained level
    set_cfg(1, 0);
    for (int i = 0; i < DEPTH - 1; i++) cyc(0, '0, 1, 0);
    chk("R4", req_pri_n, 1, "pri with one byte left");
    cyc(0, '0, 1, 0);
    chk("R4", req_pri_n, 0, "pri when drained");
    chk("R5", irq_pend, 1, "irq when drained");

    // Empty pop with concurrent write
    cyc(0, '0, 1, 0);
    cyc(1, 8'hA5, 1, 0);
    chk("R11", rd_data, 8'hA5, "byte after empty pop");
    cyc(0, '0, 1, 0);

    // Delayed release of the alternate pin
    alt_sel = 1;
    cyc(0, '0, 0, 0);
    chk("R7", req_alt_n, 0, "alt asserted");
    cyc(1, 8'h33, 0, 0);
    chk("R9", req_alt_n, 0, "alt held at cause edge");
    for (int i = 0; i < SLOW - 1; i++) begin
      cyc(0, '0, 0, 0);
      chk("R9", req_alt_n, 0, "alt still held");
    end
    cyc(0, '0, 0, 0);
    chk("R9", req_alt_n, 1, "alt released after delay");

    // Immediate release
    cyc(0, '0, 1, 0);
    set_cfg(1, 1);
    cyc(1, 8'h44, 0, 0);
    chk("R8", req_alt_n, 1, "alt released at once");

    // Channel reset clears configuration
    chan_rst = 1;
    cyc(0, '0, 0, 0);
    chan_rst = 0;
    alt_sel = 0;
    cyc(1, 8'h55, 0, 0);
    chk("R10", req_pri_n, 0, "slot-free level after channel reset");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      cfg_we = ($urandom_range(15) == 0);
      cfg_drain_lvl = $urandom_range(1);
      cfg_alt_fast  = $urandom_range(1);
      if ($urandom_range(31) == 0) req_mode_en = ~req_mode_en;
      if ($urandom_range(31) == 0) alt_sel = ~alt_sel;
      chan_rst = ($urandom_range(199) == 0);
      cyc($urandom_range(1), DATA_W'($urandom), ($urandom_range(2) == 0),
          ($urandom_range(7) == 0));
      cfg_we = 0; chan_rst = 0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule